// File: doc/BRIEF.md
# Key-Protected Dual-Side Control Register

This block is a single 32-bit control word that two buses can see. The local host bus may read it and write it. The peripheral-side bus may only read it. A host write is accepted only when the top byte of that same write carries the unlock key `8'hA5` and the top byte lane is enabled. Any other write is dropped as a whole, and a one-cycle rejection pulse is raised.

Only eight bits are stored: bits 11:8, bit 6 and bits 2:0. Every other bit, including the key byte, always reads as zero. Two of the stored bits control a downstream prefetch engine:

- bit 9 enables prefetch;
- bit 11 selects the prefetch size.

The block drives both bits out directly. It also drives a decoded prefetch byte count, which is 0, 8 or 32.

Each bus has its own registered read path. A read request is sampled on a clock edge, and the data arrives one cycle later together with a valid strobe. Reads always return the value held before any write on the same edge.

Top module: `keyed_ctrl_reg`

## Requirements
- R1: After reset, `ctrl_word`, `pf_en`, `pf_size_sel`, `pf_bytes`, `key_err`, `host_rvalid` and `per_rvalid` are all 0.
- R2: A host write with `host_wdata[31:24] == 8'hA5` and `host_be[3] == 1` updates the enabled writable bits. The new value shows on `ctrl_word` in the cycle after the write edge.
- R3: A host write with a wrong key byte, or with `host_be[3] == 0`, leaves `ctrl_word` unchanged. `key_err` is then high for exactly the one cycle after that write edge.
- R4: Bits 31:24 of `ctrl_word`, `host_rdata` and `per_rdata` always read 0, even right after a write that carried the key.
- R5: Only the bits of mask `32'h0000_0F47` can ever be 1. Bits 23:12, 7, 5, 4 and 3 read 0 whatever value is written to them.
- R6: In an accepted write, `host_be[1]` gates bits 11:8, and `host_be[0]` gates bits 6 and 2:0. A bit in a disabled lane keeps its value.
- R7: `per_we` and `per_wdata` have no effect on the stored value, even when `per_wdata[31:24]` carries the key.
- R8: A read request on either side returns the stored value in the next cycle, with its valid strobe high for that one cycle. If a host write lands on the same edge, the read returns the old value.
- R9: `pf_en` equals bit 9 and `pf_size_sel` equals bit 11. `pf_bytes` is 0 when bit 9 is 0, 8 when bits 9 and 11 are 1 and 0, and 32 when both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write request |
| host_be | input | 4 | Host byte-lane enables |
| host_wdata | input | 32 | Host write data; the top byte carries the key |
| host_re | input | 1 | Host read request |
| host_rdata | output | 32 | Host read data |
| host_rvalid | output | 1 | Host read data valid, one cycle |
| per_re | input | 1 | Peripheral read request |
| per_we | input | 1 | Peripheral write attempt (ignored) |
| per_wdata | input | 32 | Peripheral write data (ignored) |
| per_rdata | output | 32 | Peripheral read data |
| per_rvalid | output | 1 | Peripheral read data valid, one cycle |
| key_err | output | 1 | One-cycle pulse on a rejected host write |
| ctrl_word | output | 32 | Current register value |
| pf_en | output | 1 | Prefetch enable (bit 9) |
| pf_size_sel | output | 1 | Prefetch size select (bit 11) |
| pf_bytes | output | 6 | Decoded prefetch byte count |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way:

- **Near-miss keys.** The bench writes keys one bit away from `8'hA5`, and the correct key with the top lane disabled. A design that compares only part of the byte, or ignores `host_be[3]`, would take these writes and change `ctrl_word`.
- **Full data words.** It writes all-ones data with the key. A design that stores the key byte or the reserved bits would read back nonzero upper bits.
- **Partial byte enables.** It uses lane masks that cover only some fields, so that lane gating swapped between the two low bytes shows up as a wrong field.
- **Peripheral writes carrying the key.** It checks that a peripheral-side write with a valid key byte still changes nothing.
- **Simultaneous write and read.** It issues a host write and reads on both sides on the same edge. The reads must return the old value; a design that forwards the write data would return the new one.
- **Every prefetch combination.** It walks all four settings of bits 9 and 11. This catches a byte count that ignores the enable bit or swaps the 8- and 32-byte sizes.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam logic [7:0]  KEY_DEF  = 8'hA5;
  localparam logic [31:0] WR_MASK  = 32'h0000_0F47;
  localparam int unsigned BIT_PSZ  = 11;
  localparam int unsigned BIT_PEN  = 9;

  typedef struct packed {
    logic [3:0] hi_ctl;   // bits 11:8
    logic       mid_ctl;  // bit 6
    logic [2:0] lo_ctl;   // bits 2:0
  } kcr_fields_t;

  function automatic logic [31:0] fields_to_word(kcr_fields_t f);
    logic [31:0] w;
    w = '0;
    w[11:8] = f.hi_ctl;
    w[6]    = f.mid_ctl;
    w[2:0]  = f.lo_ctl;
    return w;
  endfunction
endpackage

// File: rtl/kcr_rst_sync.sv
module kcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/kcr_write_gate.sv
module kcr_write_gate #(
  parameter logic [7:0] KEY = kcr_pkg::KEY_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  be,
  input  logic [7:0]  key_byte,
  output logic        accept,
  output logic        err_q
);
  logic key_ok;
  logic reject;
  logic err_d;

  always_comb begin
    key_ok = be[3] && (key_byte == KEY);
    accept = we && key_ok;
    reject = we && !key_ok;
    err_d  = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/kcr_store.sv
module kcr_store (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [3:0]           be,
  input  logic [31:0]          wdata,
  output kcr_pkg::kcr_fields_t fields_q
);
  import kcr_pkg::*;

  kcr_fields_t fields_d;
  logic        hi_en;
  logic        lo_en;
  logic        unused_wbits;

  assign unused_wbits = ^{wdata[31:12], wdata[7], wdata[5:3], be[3:2]};

  always_comb begin
    hi_en    = accept && be[1];
    lo_en    = accept && be[0];
    fields_d = fields_q;
    if (hi_en) fields_d.hi_ctl = wdata[11:8];
    if (lo_en) begin
      fields_d.mid_ctl = wdata[6];
      fields_d.lo_ctl  = wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fields_q <= '0;
    else if (hi_en || lo_en) fields_q <= fields_d;
  end
endmodule

// File: rtl/kcr_read_port.sv
module kcr_read_port #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         re,
  input  logic [W-1:0] src,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  logic [W-1:0] rdata_d;

  always_comb rdata_d = re ? src : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/kcr_pf_decode.sv
module kcr_pf_decode #(
  parameter int unsigned SMALL_BYTES = 8,
  parameter int unsigned LARGE_BYTES = 32,
  localparam int unsigned CNT_W = $clog2(LARGE_BYTES + 1)
) (
  input  logic             enable,
  input  logic             size_sel,
  output logic [CNT_W-1:0] bytes
);
  always_comb begin
    if (!enable)       bytes = '0;
    else if (size_sel) bytes = CNT_W'(LARGE_BYTES);
    else               bytes = CNT_W'(SMALL_BYTES);
  end
endmodule

// File: rtl/keyed_ctrl_reg.sv
module keyed_ctrl_reg #(
  parameter logic [7:0]   KEY         = kcr_pkg::KEY_DEF,
  parameter int unsigned  SMALL_BYTES = 8,
  parameter int unsigned  LARGE_BYTES = 32,
  localparam int unsigned CNT_W       = $clog2(LARGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [3:0]       host_be,
  input  logic [31:0]      host_wdata,
  input  logic             host_re,
  output logic [31:0]      host_rdata,
  output logic             host_rvalid,
  input  logic             per_re,
  input  logic             per_we,
  input  logic [31:0]      per_wdata,
  output logic [31:0]      per_rdata,
  output logic             per_rvalid,
  output logic             key_err,
  output logic [31:0]      ctrl_word,
  output logic             pf_en,
  output logic             pf_size_sel,
  output logic [CNT_W-1:0] pf_bytes
);
  import kcr_pkg::*;

  localparam int unsigned SIDES = 2;

  logic        rst_sync_n;
  logic        accept;
  kcr_fields_t fields_q;
  logic        unused_per;

  logic [SIDES-1:0]        side_re;
  logic [SIDES-1:0][31:0]  side_rdata;
  logic [SIDES-1:0]        side_rvalid;

  assign unused_per = ^{per_we, per_wdata};

  kcr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kcr_write_gate #(.KEY(KEY)) u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (host_we),
    .be       (host_be),
    .key_byte (host_wdata[31:24]),
    .accept   (accept),
    .err_q    (key_err)
  );

  kcr_store u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .be       (host_be),
    .wdata    (host_wdata),
    .fields_q (fields_q)
  );

  assign ctrl_word = fields_to_word(fields_q) & WR_MASK;

  assign side_re = {per_re, host_re};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    kcr_read_port #(.W(32)) u_rd (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .re     (side_re[s]),
      .src    (ctrl_word),
      .rdata  (side_rdata[s]),
      .rvalid (side_rvalid[s])
    );
  end

  assign host_rdata  = side_rdata[0];
  assign host_rvalid = side_rvalid[0];
  assign per_rdata   = side_rdata[1];
  assign per_rvalid  = side_rvalid[1];

  assign pf_en       = ctrl_word[BIT_PEN];
  assign pf_size_sel = ctrl_word[BIT_PSZ];

  kcr_pf_decode #(
    .SMALL_BYTES (SMALL_BYTES),
    .LARGE_BYTES (LARGE_BYTES)
  ) u_pf (
    .enable   (pf_en),
    .size_sel (pf_size_sel),
    .bytes    (pf_bytes)
  );
endmodule

// File: rtl/keyed_ctrl_reg_chk.sv
module keyed_ctrl_reg_chk #(
  parameter logic [7:0] KEY = 8'hA5,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             host_we,
  input logic [3:0]       host_be,
  input logic [31:0]      host_wdata,
  input logic             host_re,
  input logic [31:0]      host_rdata,
  input logic             host_rvalid,
  input logic             per_re,
  input logic             per_we,
  input logic [31:0]      per_rdata,
  input logic             per_rvalid,
  input logic             key_err,
  input logic [31:0]      ctrl_word,
  input logic             pf_en,
  input logic [CNT_W-1:0] pf_bytes
);
  AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_we && (host_wdata[31:24] != KEY || !host_be[3])) |=> ($stable(ctrl_word) && key_err)); // R3
  AST_ERR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_we |=> !key_err); // R3
  AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_word[31:24] == 8'h00) && (host_rdata[31:24] == 8'h00) && (per_rdata[31:24] == 8'h00)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_word & ~32'h0000_0F47) == 32'h0); // R5
  AST_PER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (per_we && !host_we) |=> $stable(ctrl_word)); // R7
  AST_HOST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_re |=> (host_rvalid && host_rdata == $past(ctrl_word))); // R8
  AST_PER_READ_OLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    per_re |=> (per_rvalid && per_rdata == $past(ctrl_word))); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !per_re |=> !per_rvalid); // R8
  AST_PF_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pf_en |-> (pf_bytes == '0)); // R9
endmodule

bind keyed_ctrl_reg keyed_ctrl_reg_chk #(.KEY(KEY), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .host_we     (host_we),
  .host_be     (host_be),
  .host_wdata  (host_wdata),
  .host_re     (host_re),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .per_re      (per_re),
  .per_we      (per_we),
  .per_rdata   (per_rdata),
  .per_rvalid  (per_rvalid),
  .key_err     (key_err),
  .ctrl_word   (ctrl_word),
  .pf_en       (pf_en),
  .pf_bytes    (pf_bytes)
);

// File: tb/sim_keyed_ctrl_reg.sv
`timescale 1ns/1ps
module sim_keyed_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we, host_re, per_re, per_we;
  logic [3:0]  host_be;
  logic [31:0] host_wdata, per_wdata;
  logic [31:0] host_rdata, per_rdata, ctrl_word;
  logic        host_rvalid, per_rvalid, key_err, pf_en, pf_size_sel;
  logic [5:0]  pf_bytes;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keyed_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_be(host_be), .host_wdata(host_wdata), .host_re(host_re),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .per_re(per_re), .per_we(per_we), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_rvalid(per_rvalid),
    .key_err(key_err), .ctrl_word(ctrl_word),
    .pf_en(pf_en), .pf_size_sel(pf_size_sel), .pf_bytes(pf_bytes)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_we = 0; host_re = 0; per_re = 0; per_we = 0;
    host_be = 4'h0; host_wdata = '0; per_wdata = '0;
  endtask

  // write on one edge; returns at the following negedge with results visible
  task automatic hwrite(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    host_we = 1; host_wdata = d; host_be = be;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 ctrl_word", ctrl_word, 32'h0);
    chk("R1 flags", {27'h0, pf_en, pf_size_sel, key_err, host_rvalid, per_rvalid}, 32'h0);
    chk("R1 pf_bytes", {26'h0, pf_bytes}, 32'h0);
  endtask

  task automatic t_keyed_write();
    hwrite(32'hA500_0A45, 4'hF);
    chk("R2 keyed write", ctrl_word, 32'h0000_0A45);
    chk("R2 no err", {31'h0, key_err}, 32'h0);
    hwrite(32'hA5FF_FFFF, 4'hF);
    chk("R5 mask", ctrl_word, 32'h0000_0F47);
    chk("R4 top zero", {24'h0, ctrl_word[31:24]}, 32'h0);
  endtask

  task automatic t_bad_key();
    foreach (bad_keys[i]) begin
      hwrite({bad_keys[i], 24'h000000}, 4'hF);
      chk("R3 bad key holds", ctrl_word, 32'h0000_0F47);
      chk("R3 err pulse", {31'h0, key_err}, 32'h1);
      @(negedge clk);
      chk("R3 err one cycle", {31'h0, key_err}, 32'h0);
    end
    hwrite(32'hA500_0000, 4'h7);
    chk("R3 no top lane", ctrl_word, 32'h0000_0F47);
    chk("R3 err no lane", {31'h0, key_err}, 32'h1);
  endtask
  logic [7:0] bad_keys [4] = '{8'hA4, 8'h25, 8'hA7, 8'h00};

  task automatic t_byte_enables();
    hwrite(32'hA500_0000, 4'hA);
    chk("R6 lane1 only", ctrl_word, 32'h0000_0047);
    hwrite(32'hA500_0F00, 4'h9);
    chk("R6 lane0 only", ctrl_word, 32'h0000_0000);
    hwrite(32'hA500_0341, 4'hB);
    chk("R6 both lanes", ctrl_word, 32'h0000_0341);
  endtask

  task automatic t_per_write();
    @(negedge clk);
    per_we = 1; per_wdata = 32'hA5FF_FFFF;
    @(negedge clk);
    idle();
    chk("R7 per write ignored", ctrl_word, 32'h0000_0341);
  endtask

  task automatic t_collision();
    @(negedge clk);
    host_we = 1; host_be = 4'hF; host_wdata = 32'hA500_0C06;
    host_re = 1; per_re = 1;
    @(negedge clk);
    idle();
    chk("R8 host old value", host_rdata, 32'h0000_0341);
    chk("R8 per old value", per_rdata, 32'h0000_0341);
    chk("R8 valids", {30'h0, host_rvalid, per_rvalid}, 32'h3);
    chk("R2 new value", ctrl_word, 32'h0000_0C06);
    @(negedge clk);
    chk("R8 valids drop", {30'h0, host_rvalid, per_rvalid}, 32'h0);
    per_re = 1;
    @(negedge clk);
    per_re = 0;
    chk("R8 per new value", per_rdata, 32'h0000_0C06);
    chk("R4 per rdata top", {24'h0, per_rdata[31:24]}, 32'h0);
  endtask

  task automatic t_prefetch();
    for (int m = 0; m < 4; m++) begin
      logic en, sz;
      logic [5:0] exp_b;
      en = m[0]; sz = m[1];
      hwrite({8'hA5, 12'h0, sz, 1'b0, en, 1'b0, 8'h00}, 4'hA);
      exp_b = !en ? 6'd0 : (sz ? 6'd32 : 6'd8);
      chk("R9 pf_bytes", {26'h0, pf_bytes}, {26'h0, exp_b});
      chk("R9 pf flags", {30'h0, pf_en, pf_size_sel}, {30'h0, en, sz});
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_keyed_write();
    t_bad_key();
    t_byte_enables();
    t_per_write();
    t_collision();
    t_prefetch();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule